// File: doc/BRIEF.md
# Bit-Selected Reset PWM Generator

This block produces a pulse-width-modulated output from a single free-running counter. The counter advances on a slow tick enable (nominally 32 kHz) supplied from outside. The period is not held in a period register. A 2-bit prescaler instead chooses which counter bit ends the period: as soon as the incremented count would set that bit, the counter goes back to zero. Prescaler values 0, 1, 2 and 3 therefore give periods of 128, 64, 32 and 16 ticks. At a 32 kHz tick these are 250 Hz, 500 Hz, 1 kHz and 2 kHz.

A 7-bit duty value is compared with the active low bits of the counter, called the phase. The output is high while the phase is below the duty value. Software programs the block through a small write port with two addresses, a control register and a duty register, and reads both back combinationally. Duty and prescaler writes act at once. No counter reset and no end-of-period shadowing are applied. Because the duty value tops out at 127, the slowest setting always keeps one low tick per period.

A two-state controller governs the block. In `ST_OFF` the counter is held at zero, the output is low and `pin_idle` is high, so external pin muxing can hand the pin to another function. The transition *start* (enable bit set) moves the controller to `ST_RUN`, where the output follows the comparison. The transition *stop* (enable bit cleared) returns it to `ST_OFF`. The controller state follows the enable bit with one cycle of delay.

Top module: `pwm_bitreset_top`

## Requirements
- R1: After reset, both registers read as zero, `pwm_out` is 0 and `pin_idle` is 1.
- R2: Address 0 is the control register: bit 0 is enable and bits [2:1] are the prescaler. Address 1 is the duty register, bits [6:0]. A write with `wr_en` high updates the addressed register at the clock edge. `rd_data` shows the register selected by `rd_addr`, with unused bits reading 0.
- R3: While running, the counter advances by one on each cycle with `tick_en` high. For prescaler p it returns to 0 instead of reaching 2^(7-p), so the period is 128, 64, 32 or 16 ticks for p = 0, 1, 2 or 3.
- R4: In `ST_RUN`, `pwm_out` is 1 exactly when the phase (counter modulo the period) is less than the duty value.
- R5: A duty value at or above the period holds `pwm_out` at 1 for the whole period. At prescaler 0 the largest duty, 127, gives 127 high ticks and 1 low tick per period.
- R6: A duty write is visible at `pwm_out` in the cycle right after the write edge, in the middle of a period, with no wait for the period to end.
- R7: A prescaler change does not clear the counter. The counter keeps counting from its current value until the newly selected reset bit would be set, then restarts at 0.
- R8: One cycle after the enable bit is cleared, the block is in `ST_OFF`: `pwm_out` is 0 and `pin_idle` is 1, whatever the duty value. The counter is zero when the block re-enters `ST_RUN`, so the phase restarts at 0.
- R9: With `tick_en` low, the counter and `pwm_out` hold. Counting resumes from the same phase once `tick_en` returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counter advance enable (one pulse per tick) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address (0 control, 1 duty) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address (0 control, 1 duty) |
| rd_data | output | 8 | Read data of the selected register |
| pwm_out | output | 1 | PWM output |
| pin_idle | output | 1 | High when the generator is off and the pin may return to another function |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 2-bit prescaler and a 7-bit duty. This makes the whole setting space small enough to sweep in full. Every prescaler is combined with every one of the 128 duty values and run for two complete periods, so every phase/duty comparison is checked, including the full-on cases and the single low tick at prescaler 0. Directed runs then cover a prescaler switch from count 100, a duty change in mid-period, tick gating and the off state.

// File: rtl/pwm_br_pkg.sv
package pwm_br_pkg;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } pwm_state_e;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DUTY = 1'b1;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_PRE_LSB = 1;

endpackage

// File: rtl/pwm_br_regs.sv
module pwm_br_regs
    import pwm_br_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 2,
    parameter int DUTY_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              en_o,
    output logic [PRE_W-1:0]  pre_o,
    output logic [DUTY_W-1:0] duty_o
);

    logic              en_q;
    logic [PRE_W-1:0]  pre_q;
    logic [DUTY_W-1:0] duty_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            pre_q  <= '0;
            duty_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL) begin
                en_q  <= wr_data[CTRL_EN_BIT];
                pre_q <= wr_data[CTRL_PRE_LSB +: PRE_W];
            end else begin
                duty_q <= wr_data[DUTY_W-1:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_CTRL) begin
            rd_data[CTRL_EN_BIT]            = en_q;
            rd_data[CTRL_PRE_LSB +: PRE_W]  = pre_q;
        end else begin
            rd_data[DUTY_W-1:0] = duty_q;
        end
    end

    assign en_o   = en_q;
    assign pre_o  = pre_q;
    assign duty_o = duty_q;

    // R2: duty write lands at the next edge
    p_duty_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_DUTY) |=> duty_o == $past(wr_data[DUTY_W-1:0]));

    // R2: control write lands at the next edge
    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL) |=>
            (en_o == $past(wr_data[CTRL_EN_BIT]) &&
             pre_o == $past(wr_data[CTRL_PRE_LSB +: PRE_W])));

endmodule

// File: rtl/pwm_br_counter.sv
module pwm_br_counter #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [PRE_W-1:0] pre_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam int IDX_W = $clog2(CNT_W);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [IDX_W-1:0] rst_bit;
    logic [CNT_W-1:0] top_val;

    always_comb begin
        rst_bit = IDX_W'(CNT_W - 1) - IDX_W'(pre_i);
        cnt_inc = cnt_q + CNT_W'(1);
        top_val = (CNT_W'(1) << rst_bit) - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_inc[rst_bit]) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_inc;
            end
        end
    end

    assign cnt_o = cnt_q;

    // R8: counter parked at zero while stopped
    p_clear_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_o == '0);

    // R9: no tick, no movement
    p_hold_notick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(cnt_o));

    // R3: last phase of the period wraps to zero
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && cnt_o == top_val) |=> cnt_o == '0);

    // R3: below the last phase the counter steps by one
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && cnt_o < top_val) |=> cnt_o == $past(cnt_o) + CNT_W'(1));

endmodule

// File: rtl/pwm_br_compare.sv
module pwm_br_compare #(
    parameter int CNT_W  = 8,
    parameter int PRE_W  = 2,
    parameter int DUTY_W = 7
) (
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [PRE_W-1:0]  pre_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic [CNT_W-1:0]  period_o,
    output logic              hit_o
);

    localparam int NUM_PRE = 1 << PRE_W;

    logic [CNT_W-1:0] mask_tab   [NUM_PRE];
    logic [CNT_W-1:0] period_tab [NUM_PRE];
    logic [CNT_W-1:0] phase;

    for (genvar g = 0; g < NUM_PRE; g++) begin : g_sel
        assign period_tab[g] = CNT_W'(1) << (CNT_W - 1 - g);
        assign mask_tab[g]   = period_tab[g] - CNT_W'(1);
    end

    always_comb begin
        phase    = cnt_i & mask_tab[pre_i];
        period_o = period_tab[pre_i];
        hit_o    = phase < CNT_W'(duty_i);
    end

endmodule

// File: rtl/pwm_bitreset_top.sv
module pwm_bitreset_top
    import pwm_br_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PRE_W  = 2,
    parameter int DUTY_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_out,
    output logic              pin_idle
);

    logic              en;
    logic [PRE_W-1:0]  pre;
    logic [DUTY_W-1:0] duty;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  period;
    logic              hit;
    logic              run;

    pwm_state_e state_q, state_d;

    pwm_br_regs #(
        .DATA_W (DATA_W),
        .PRE_W  (PRE_W),
        .DUTY_W (DUTY_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .en_o    (en),
        .pre_o   (pre),
        .duty_o  (duty)
    );

    pwm_br_counter #(
        .CNT_W (CNT_W),
        .PRE_W (PRE_W)
    ) counter_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_i (tick_en),
        .pre_i  (pre),
        .cnt_o  (cnt)
    );

    pwm_br_compare #(
        .CNT_W  (CNT_W),
        .PRE_W  (PRE_W),
        .DUTY_W (DUTY_W)
    ) compare_i (
        .cnt_i    (cnt),
        .pre_i    (pre),
        .duty_i   (duty),
        .period_o (period),
        .hit_o    (hit)
    );

    // next-state logic: start / stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (en)  state_d = ST_RUN;
            ST_RUN: if (!en) state_d = ST_OFF;
            default:         state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs per state
    always_comb begin
        run      = 1'b0;
        pwm_out  = 1'b0;
        pin_idle = 1'b1;
        unique case (state_q)
            ST_OFF: begin
                run      = 1'b0;
                pwm_out  = 1'b0;
                pin_idle = 1'b1;
            end
            ST_RUN: begin
                run      = 1'b1;
                pwm_out  = hit;
                pin_idle = 1'b0;
            end
            default: ;
        endcase
    end

    // R8: idle pin flag and active output never coincide
    p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pin_idle |-> !pwm_out);

    // R8: controller follows the enable bit one cycle later
    p_follow_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> !pin_idle);

    // R5: duty at or above the period keeps the output high
    p_full_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_idle && cnt < period && CNT_W'(duty) >= period) |-> pwm_out);

endmodule

// File: tb/pwm_bitreset_tb.sv
module pwm_bitreset_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       pwm_out;
    logic       pin_idle;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_bitreset_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .pwm_out  (pwm_out),
        .pin_idle (pin_idle)
    );

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // write lands on the next rising edge; returns at the following falling edge
    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int period_of(input int p);
        return 128 >> p;
    endfunction

    task automatic stop_and_clear();
        tick_en = 1'b0;
        wr(1'b0, 8'h00);
        @(negedge clk);
        @(negedge clk);
    endtask

    // configure and enable; returns with the block running at phase 0
    task automatic start(input int p, input int d);
        stop_and_clear();
        wr(1'b1, 8'(d));
        wr(1'b0, 8'((p << 1) | 1));
        @(negedge clk);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_addr = 1'b0; #1; chk(rd_data, 8'h00, "R1 ctrl");
        rd_addr = 1'b1; #1; chk(rd_data, 8'h00, "R1 duty");
        chk(8'(pwm_out), 8'd0, "R1 pwm_out");
        chk(8'(pin_idle), 8'd1, "R1 pin_idle");

        // R2/R3/R4/R5: every prescaler with every duty, two periods each
        for (int p = 0; p < 4; p++) begin
            for (int d = 0; d < 128; d++) begin
                start(p, d);
                if (d == 77) begin
                    rd_addr = 1'b0; #1; chk(rd_data, 8'((p << 1) | 1), "R2 ctrl readback");
                    rd_addr = 1'b1; #1; chk(rd_data, 8'(d), "R2 duty readback");
                end
                chk(8'(pin_idle), 8'd0, "R8 running pin_idle");
                tick_en = 1'b1;
                for (int i = 0; i < 2 * period_of(p); i++) begin
                    if (d >= period_of(p))
                        chk(8'(pwm_out), 8'd1, "R5 full duty");
                    else
                        chk(8'(pwm_out), 8'((i % period_of(p)) < d), "R3 R4 phase compare");
                    @(negedge clk);
                end
            end
        end

        // R5: prescaler 0, duty 127: exactly one low tick per period
        start(0, 127);
        tick_en = 1'b1;
        begin
            int lows = 0;
            for (int i = 0; i < 256; i++) begin
                if (!pwm_out) lows++;
                @(negedge clk);
            end
            chk(8'(lows), 8'd2, "R5 low ticks in two periods");
        end

        // R6: duty change mid-period takes effect immediately
        start(2, 3);
        tick_en = 1'b1;
        repeat (10) @(negedge clk);
        tick_en = 1'b0;
        chk(8'(pwm_out), 8'd0, "R6 before duty write");
        wr(1'b1, 8'd20);
        chk(8'(pwm_out), 8'd1, "R6 after duty write");
        wr(1'b1, 8'd10);
        chk(8'(pwm_out), 8'd0, "R6 duty equal to phase");

        // R7: switch prescaler 0 -> 3 at count 100, counter not cleared
        start(0, 5);
        tick_en = 1'b1;
        repeat (100) @(negedge clk);
        tick_en = 1'b0;
        wr(1'b0, 8'((3 << 1) | 1));
        tick_en = 1'b1;
        for (int k = 0; k < 40; k++) begin
            int ph;
            ph = (k < 12) ? (4 + k) : ((k - 12) % 16);
            chk(8'(pwm_out), 8'(ph < 5), "R7 prescaler switch phase");
            @(negedge clk);
        end

        // R9: tick gating freezes the phase
        start(3, 8);
        tick_en = 1'b1;
        repeat (5) @(negedge clk);
        tick_en = 1'b0;
        for (int k = 0; k < 20; k++) begin
            chk(8'(pwm_out), 8'd1, "R9 held phase 5");
            @(negedge clk);
        end
        tick_en = 1'b1;
        for (int k = 0; k < 12; k++) begin
            chk(8'(pwm_out), 8'(((5 + k) % 16) < 8), "R9 resume phase");
            @(negedge clk);
        end

        // R8: disable forces idle regardless of duty, restart from phase 0
        start(1, 127);
        tick_en = 1'b1;
        repeat (7) @(negedge clk);
        chk(8'(pwm_out), 8'd1, "R8 running high");
        wr(1'b0, 8'((1 << 1) | 0));
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            chk(8'(pwm_out), 8'd0, "R8 off output");
            chk(8'(pin_idle), 8'd1, "R8 off pin_idle");
            @(negedge clk);
        end
        tick_en = 1'b0;
        wr(1'b1, 8'd1);
        wr(1'b0, 8'((1 << 1) | 1));
        @(negedge clk);
        chk(8'(pwm_out), 8'd1, "R8 restart phase 0");
        tick_en = 1'b1;
        @(negedge clk);
        chk(8'(pwm_out), 8'd0, "R8 restart phase 1");

        report();
    end

endmodule